// File: doc/BRIEF.md
# Hardware Breakpoint and Cycle-Measure Unit

This unit sits beside a processor core and watches two address streams: the addresses of instruction fetches and the addresses of data accesses. A bank of programmable comparators checks every valid address. Each comparator has three settings:

- which stream or streams it watches;
- what a match means: halt, start a cycle measurement, or stop one;
- the address it compares against.

When a halt comparator matches, the unit raises a halt request to the core. The request stays up until a resume command arrives. The unit records the lowest-numbered comparator that matched.

Start and stop comparators drive a cycle counter. The counter measures the clock cycles between two points in the program without ever touching the halt request, so execution timing is not disturbed. While the core is halted, a step command lets exactly one instruction retire and then halts the core again. An optional freeze output tells peripherals to stop while the core is halted.

Comparators are programmed one at a time through a write port. A write carries the comparator index, enable bit, stream mask, role and compare address.

Top module: `brk_measure_top`

## Requirements
- R1: After reset, haltReq, hitValid, measBusy, measDone and freezeOut are 0, measCount is 0, and every comparator is disabled.
- R2: A comparator matches in a cycle when all of the following hold: it is enabled; it watches a stream (cmpKind bit 0 = fetch stream, bit 1 = data stream); that stream's valid is 1; and that stream's address equals the comparator's compare address. A disabled comparator never matches.
- R3: While running, a match on any comparator with role 0 (halt) sets haltReq to 1 at the next clock edge. haltReq then stays 1 until a resume or step command.
- R4: When a halt is taken, hitIdx holds the lowest-numbered matching halt comparator and hitValid is 1. Halt matches that occur while halted do not change hitIdx.
- R5: A resume command (resumeCmd = 1) clears haltReq and hitValid at the next edge. Resume has priority over a step command.
- R6: A match on a comparator with role 1 (start) clears measCount to 0 and sets measBusy. While busy, measCount increments once per cycle. A match with role 2 (stop) counts that cycle, clears measBusy and sets measDone. The result then holds until the next start.
- R7: measCount saturates at its all-ones value and never wraps.
- R8: Start and stop matches never raise haltReq. Role 3 has no effect.
- R9: While halted, stepCmd = 1 drops haltReq at the next edge. haltReq stays 0 until a cycle with retire = 1, and is 1 again at the following edge. hitIdx and hitValid are kept through the step.
- R10: freezeOut is 1 exactly when freezeEnable is 1 and the core is halted, that is, haltReq is 1 and no step is in progress.
- R11: A new start match clears measDone at the next edge.
- R12: When cfgWe is 1, the comparator selected by cfgIdx takes the new settings at that edge. A match can use them from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Comparator write strobe |
| cfgIdx | input | IDX_W | Comparator to write |
| cfgEnable | input | 1 | Enable bit to write |
| cfgKind | input | 2 | Stream mask: bit 0 fetch, bit 1 data |
| cfgRole | input | 2 | 0 halt, 1 start, 2 stop, 3 none |
| cfgAddr | input | ADDR_W | Compare address to write |
| fetchValid | input | 1 | Fetch address valid |
| fetchAddr | input | ADDR_W | Fetch address |
| dataValid | input | 1 | Data access address valid |
| dataAddr | input | ADDR_W | Data access address |
| resumeCmd | input | 1 | Leave the halted state |
| stepCmd | input | 1 | Execute one instruction, then halt again |
| retire | input | 1 | Core retired an instruction this cycle |
| freezeEnable | input | 1 | Allow the peripheral freeze output |
| haltReq | output | 1 | Halt request to the core |
| freezeOut | output | 1 | Peripheral freeze |
| hitValid | output | 1 | A halt comparator hit is recorded |
| hitIdx | output | IDX_W | Lowest-numbered halt comparator that hit |
| measBusy | output | 1 | Measurement in progress |
| measDone | output | 1 | Measurement complete |
| measCount | output | CNT_W | Measured cycle count |

## Verification
Some properties are checked by assertions on every cycle:

- the halt request is held until a resume or step;
- resume clears the hit record;
- a retire during a step halts the core again;
- freeze implies halt;
- a stop ends a measurement and sets the done flag;
- a start clears the done flag;
- the counter stays at its all-ones value.

Other behaviour only the bench scenarios can show:

- which comparator wins when several match at once;
- the stream-mask and enable decoding;
- that a freshly written comparator takes effect;
- the exact measured cycle counts;
- saturation, shown on a narrow-counter instance.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ROLE_HALT  = 2'd0,
    ROLE_START = 2'd1,
    ROLE_STOP  = 2'd2,
    ROLE_NONE  = 2'd3
  } roleT;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STEP = 2'd2
  } dbgStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic cntZero;
    logic cntInc;
    logic capHit;
  } ctlStrobeT;
endpackage

// File: rtl/brk_datapath.sv
module brk_datapath
  import brk_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int IDX_W   = $clog2(NUM_CMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgKind,
  input  logic [1:0]        cfgRole,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  ctlStrobeT         strobe,
  output logic              breakHit,
  output logic              startHit,
  output logic              stopHit,
  output logic [IDX_W-1:0]  hitIdx,
  output logic [CNT_W-1:0]  measCount
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_CMP-1:0] cmpEn;
  logic [1:0]         cmpKind [NUM_CMP];
  roleT               cmpRole [NUM_CMP];
  logic [ADDR_W-1:0]  cmpAddr [NUM_CMP];
  logic [NUM_CMP-1:0] matchVec;
  logic [NUM_CMP-1:0] breakVec;
  logic [NUM_CMP-1:0] startVec;
  logic [NUM_CMP-1:0] stopVec;
  logic [IDX_W-1:0]   winIdx;
  logic [CNT_W-1:0]   cntQ;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmpEn[i]   <= 1'b0;
        cmpKind[i] <= 2'b00;
        cmpRole[i] <= ROLE_NONE;
        cmpAddr[i] <= '0;
      end else if (cfgWe && cfgIdx == IDX_W'(i)) begin
        cmpEn[i]   <= cfgEnable;
        cmpKind[i] <= cfgKind;
        cmpRole[i] <= roleT'(cfgRole);
        cmpAddr[i] <= cfgAddr;
      end
    end

    assign matchVec[i] = cmpEn[i] &&
      ((cmpKind[i][0] && fetchValid && fetchAddr == cmpAddr[i]) ||
       (cmpKind[i][1] && dataValid  && dataAddr  == cmpAddr[i]));
    assign breakVec[i] = matchVec[i] && cmpRole[i] == ROLE_HALT;
    assign startVec[i] = matchVec[i] && cmpRole[i] == ROLE_START;
    assign stopVec[i]  = matchVec[i] && cmpRole[i] == ROLE_STOP;
  end

  // lowest index wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_CMP - 1; i >= 0; i--) begin
      if (breakVec[i]) winIdx = IDX_W'(i);
    end
  end

  assign breakHit = |breakVec;
  assign startHit = |startVec;
  assign stopHit  = |stopVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hitIdx <= '0;
    else if (strobe.capHit) hitIdx <= winIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cntQ <= '0;
    else if (strobe.cntZero) cntQ <= '0;
    else if (strobe.cntInc && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  assign measCount = cntQ;

  // R7
  satur_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cntQ == CNT_MAX && !strobe.cntZero) |=> cntQ == CNT_MAX);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cntInc && !strobe.cntZero && cntQ != CNT_MAX) |=> cntQ == $past(cntQ) + 1'b1);
endmodule

// File: rtl/brk_control.sv
module brk_control
  import brk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      breakHit,
  input  logic      startHit,
  input  logic      stopHit,
  input  logic      resumeCmd,
  input  logic      stepCmd,
  input  logic      retire,
  input  logic      freezeEnable,
  output ctlStrobeT strobe,
  output logic      haltReq,
  output logic      freezeOut,
  output logic      hitValid,
  output logic      measBusy,
  output logic      measDone
);
  dbgStateT state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_RUN:  if (breakHit) stateNext = ST_HALT;
      ST_HALT: if (resumeCmd) stateNext = ST_RUN;
               else if (stepCmd) stateNext = ST_STEP;
      ST_STEP: if (resumeCmd) stateNext = ST_RUN;
               else if (retire) stateNext = ST_HALT;
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      hitValid <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_RUN && breakHit) hitValid <= 1'b1;
      else if (resumeCmd && state != ST_RUN) hitValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      measBusy <= 1'b0;
      measDone <= 1'b0;
    end else if (startHit) begin
      measBusy <= 1'b1;
      measDone <= 1'b0;
    end else if (measBusy && stopHit) begin
      measBusy <= 1'b0;
      measDone <= 1'b1;
    end
  end

  assign strobe.cntZero = startHit;
  assign strobe.cntInc  = measBusy && !startHit;
  assign strobe.capHit  = state == ST_RUN && breakHit;

  assign haltReq   = state == ST_HALT;
  assign freezeOut = freezeEnable && state == ST_HALT;

  // R3
  halt_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (haltReq && !resumeCmd && !stepCmd) |=> haltReq);

  // R5
  resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (haltReq && resumeCmd) |=> (!haltReq && !hitValid));

  // R9
  step_rehalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STEP && retire && !resumeCmd) |=> (haltReq && $stable(hitValid)));

  // R8
  meas_no_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!haltReq && state != ST_STEP && !breakHit) |=> !haltReq);

  // R10
  freeze_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freezeOut |-> (haltReq && freezeEnable));

  // R6
  meas_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (measBusy && stopHit && !startHit) |=> (measDone && !measBusy));

  // R11
  meas_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    startHit |=> (!measDone && measBusy));
endmodule

// File: rtl/brk_measure_top.sv
module brk_measure_top
  import brk_pkg::*;
#(
  parameter int NUM_CMP = 16,
  parameter int ADDR_W  = 32,
  parameter int CNT_W   = 32,
  parameter int IDX_W   = $clog2(NUM_CMP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              cfgEnable,
  input  logic [1:0]        cfgKind,
  input  logic [1:0]        cfgRole,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic              fetchValid,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              dataValid,
  input  logic [ADDR_W-1:0] dataAddr,
  input  logic              resumeCmd,
  input  logic              stepCmd,
  input  logic              retire,
  input  logic              freezeEnable,
  output logic              haltReq,
  output logic              freezeOut,
  output logic              hitValid,
  output logic [IDX_W-1:0]  hitIdx,
  output logic              measBusy,
  output logic              measDone,
  output logic [CNT_W-1:0]  measCount
);
  ctlStrobeT strobe;
  logic breakHit, startHit, stopHit;

  brk_datapath #(
    .NUM_CMP(NUM_CMP), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n),
    .cfgWe(cfgWe), .cfgIdx(cfgIdx), .cfgEnable(cfgEnable),
    .cfgKind(cfgKind), .cfgRole(cfgRole), .cfgAddr(cfgAddr),
    .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .dataValid(dataValid), .dataAddr(dataAddr),
    .strobe(strobe),
    .breakHit(breakHit), .startHit(startHit), .stopHit(stopHit),
    .hitIdx(hitIdx), .measCount(measCount)
  );

  brk_control ctl_i (
    .clk(clk), .rst_n(rst_n),
    .breakHit(breakHit), .startHit(startHit), .stopHit(stopHit),
    .resumeCmd(resumeCmd), .stepCmd(stepCmd), .retire(retire),
    .freezeEnable(freezeEnable),
    .strobe(strobe),
    .haltReq(haltReq), .freezeOut(freezeOut), .hitValid(hitValid),
    .measBusy(measBusy), .measDone(measDone)
  );
endmodule

// File: tb/brk_measure_top_tb.sv
module brk_measure_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic cfgWe = 0;
  logic [3:0] cfgIdx = 0;
  logic cfgEnable = 0;
  logic [1:0] cfgKind = 0, cfgRole = 0;
  logic [31:0] cfgAddr = 0;
  logic fetchValid = 0, dataValid = 0;
  logic [31:0] fetchAddr = 0, dataAddr = 0;
  logic resumeCmd = 0, stepCmd = 0, retire = 0, freezeEnable = 0;
  logic haltReq, freezeOut, hitValid, measBusy, measDone;
  logic [3:0] hitIdx;
  logic [31:0] measCount;
  logic sHalt, sFreeze, sHitV, sBusy, sDone;
  logic [3:0] sIdx;
  logic [3:0] sCount;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  brk_measure_top dut_i (
    .clk, .rst_n, .cfgWe, .cfgIdx, .cfgEnable, .cfgKind, .cfgRole, .cfgAddr,
    .fetchValid, .fetchAddr, .dataValid, .dataAddr, .resumeCmd, .stepCmd,
    .retire, .freezeEnable, .haltReq, .freezeOut, .hitValid, .hitIdx,
    .measBusy, .measDone, .measCount
  );

  brk_measure_top #(.CNT_W(4)) dutSat_i (
    .clk, .rst_n, .cfgWe, .cfgIdx, .cfgEnable, .cfgKind, .cfgRole, .cfgAddr,
    .fetchValid, .fetchAddr, .dataValid, .dataAddr, .resumeCmd, .stepCmd,
    .retire, .freezeEnable, .haltReq(sHalt), .freezeOut(sFreeze),
    .hitValid(sHitV), .hitIdx(sIdx), .measBusy(sBusy), .measDone(sDone),
    .measCount(sCount)
  );

  typedef struct packed {
    logic        fv;
    logic [31:0] fa;
    logic        dv;
    logic [31:0] da;
    logic        expHalt;
    logic [3:0]  expIdx;
  } vecT;

  localparam int NVEC = 10;
  localparam vecT TBL [NVEC] = '{
    '{1'b1, 32'h1000, 1'b0, 32'h0,    1'b1, 4'd2},   // fetch hits 2 and 9: lowest wins
    '{1'b0, 32'h0,    1'b1, 32'h2000, 1'b1, 4'd5},   // data-only comparator
    '{1'b1, 32'h2000, 1'b0, 32'h0,    1'b0, 4'd0},   // data comparator ignores fetch
    '{1'b1, 32'h3000, 1'b0, 32'h0,    1'b1, 4'd7},   // both-stream comparator, fetch side
    '{1'b0, 32'h0,    1'b1, 32'h3000, 1'b1, 4'd7},   // both-stream comparator, data side
    '{1'b1, 32'h4000, 1'b0, 32'h0,    1'b0, 4'd0},   // disabled comparator
    '{1'b0, 32'h0,    1'b1, 32'h1000, 1'b1, 4'd12},  // fetch-only 2 ignores data
    '{1'b1, 32'h3000, 1'b1, 32'h2000, 1'b1, 4'd5},   // 5 and 7 together: 5 wins
    '{1'b0, 32'h1000, 1'b0, 32'h0,    1'b0, 4'd0},   // valid low
    '{1'b1, 32'h5000, 1'b0, 32'h0,    1'b0, 4'd0}    // start role: no halt
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wrCmp(input int idx, input logic en, input logic [1:0] kind,
                       input logic [1:0] role, input logic [31:0] addr);
    cfgWe = 1; cfgIdx = 4'(idx); cfgEnable = en; cfgKind = kind;
    cfgRole = role; cfgAddr = addr;
    cyc(1);
    cfgWe = 0;
  endtask

  task automatic fetchOne(input logic [31:0] a);
    fetchValid = 1; fetchAddr = a;
    cyc(1);
    fetchValid = 0;
  endtask

  task automatic resume();
    resumeCmd = 1;
    cyc(1);
    resumeCmd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    chk("R1 haltReq", 32'(haltReq), 0);
    chk("R1 hitValid", 32'(hitValid), 0);
    chk("R1 measBusy", 32'(measBusy), 0);
    chk("R1 measDone", 32'(measDone), 0);
    chk("R1 measCount", measCount, 0);
    chk("R1 freezeOut", 32'(freezeOut), 0);
    fetchOne(32'h0);
    chk("R1 comparators disabled", 32'(haltReq), 0);

    // roles: 0 halt, 1 start, 2 stop, 3 none; kind bit0 fetch, bit1 data
    wrCmp(2,  1, 2'b01, 2'd0, 32'h1000);
    wrCmp(5,  1, 2'b10, 2'd0, 32'h2000);
    wrCmp(7,  1, 2'b11, 2'd0, 32'h3000);
    wrCmp(9,  1, 2'b01, 2'd0, 32'h1000);
    wrCmp(3,  0, 2'b01, 2'd0, 32'h4000);
    wrCmp(10, 1, 2'b01, 2'd1, 32'h5000);
    wrCmp(11, 1, 2'b01, 2'd2, 32'h6000);
    wrCmp(12, 1, 2'b10, 2'd0, 32'h1000);
    wrCmp(13, 1, 2'b01, 2'd3, 32'h7000);

    // table walk: R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      fetchValid = TBL[v].fv; fetchAddr = TBL[v].fa;
      dataValid = TBL[v].dv; dataAddr = TBL[v].da;
      cyc(1);
      fetchValid = 0; dataValid = 0;
      chk($sformatf("R2/R3 vec%0d haltReq", v), 32'(haltReq), 32'(TBL[v].expHalt));
      chk($sformatf("R4 vec%0d hitValid", v), 32'(hitValid), 32'(TBL[v].expHalt));
      if (TBL[v].expHalt) chk($sformatf("R4 vec%0d hitIdx", v), 32'(hitIdx), 32'(TBL[v].expIdx));
      cyc(1);
      chk($sformatf("R3 vec%0d held", v), 32'(haltReq), 32'(TBL[v].expHalt));
      resume();
      chk($sformatf("R5 vec%0d haltReq", v), 32'(haltReq), 0);
      chk($sformatf("R5 vec%0d hitValid", v), 32'(hitValid), 0);
    end

    // R8 role 3 comparator does nothing
    fetchOne(32'h7000);
    chk("R8 role none no halt", 32'(haltReq), 0);

    // R12 enable comparator 3 then hit it
    wrCmp(3, 1, 2'b01, 2'd0, 32'h4000);
    fetchOne(32'h4000);
    chk("R12 new cfg halt", 32'(haltReq), 1);
    chk("R12 new cfg idx", 32'(hitIdx), 3);
    // R4 hit while halted ignored
    fetchOne(32'h1000);
    chk("R4 idx kept while halted", 32'(hitIdx), 3);
    // R10 freeze
    freezeEnable = 1;
    #1;
    chk("R10 freeze on halt", 32'(freezeOut), 1);
    freezeEnable = 0;
    #1;
    chk("R10 freeze disabled", 32'(freezeOut), 0);
    freezeEnable = 1;
    // R5 resume beats step
    resumeCmd = 1; stepCmd = 1;
    cyc(1);
    resumeCmd = 0; stepCmd = 0;
    chk("R5 resume priority", 32'(haltReq), 0);
    chk("R10 freeze off when running", 32'(freezeOut), 0);

    // R9 single step
    fetchOne(32'h1000);
    chk("R9 halted before step", 32'(haltReq), 1);
    stepCmd = 1;
    cyc(1);
    stepCmd = 0;
    chk("R9 step releases", 32'(haltReq), 0);
    chk("R10 freeze off while stepping", 32'(freezeOut), 0);
    cyc(2);
    chk("R9 waits for retire", 32'(haltReq), 0);
    retire = 1;
    cyc(1);
    retire = 0;
    chk("R9 rehalt after retire", 32'(haltReq), 1);
    chk("R9 idx kept", 32'(hitIdx), 2);
    chk("R9 hitValid kept", 32'(hitValid), 1);
    resume();
    freezeEnable = 0;

    // R6 measurement: 9 idle edges between start and stop -> 10
    fetchOne(32'h5000);
    chk("R6 busy after start", 32'(measBusy), 1);
    chk("R6 count zero at start", measCount, 0);
    cyc(9);
    fetchOne(32'h6000);
    chk("R6 done", 32'(measDone), 1);
    chk("R6 not busy", 32'(measBusy), 0);
    chk("R6 count", measCount, 10);
    chk("R8 no halt from measure", 32'(haltReq), 0);
    cyc(3);
    chk("R6 count holds", measCount, 10);
    chk("R7 narrow below max", 32'(sCount), 10);

    // R11 re-arm clears done; R7 saturation on narrow instance
    fetchOne(32'h5000);
    chk("R11 done cleared", 32'(measDone), 0);
    chk("R11 count cleared", measCount, 0);
    cyc(20);
    fetchOne(32'h6000);
    chk("R6 long count", measCount, 21);
    chk("R7 saturated", 32'(sCount), 15);
    chk("R7 narrow done", 32'(sDone), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule